// File: doc/BRIEF.md
# Prioritized Fault Commit Controller

This block is the final stage of a processor whose results are re-checked before they become architectural. Every cycle at most one completed instruction arrives in program order, carrying its program counter, its successor program counter, the result the core produced, and the verdicts of three independent checkers. Each verdict comes with the value that would repair the error: a register operand, a memory operand, or a recomputed result. When no checker objects, the instruction retires on the next cycle.

When any checker objects, or when no instruction has retired for too long, the block picks the single most urgent fault. It records that cause and counts it. It then runs a fixed recovery sequence. For one cycle it resets the checker pipes with the repair value, restarts them at the faulting PC, and flushes the core so that the core refetches from the following PC. A quiet cycle follows before normal operation resumes. A forward-progress timer covers a core that has stalled. When the timer runs out, the block re-injects the next expected instruction with all-zero operands and results, and the checkers then repair it one fault at a time.

Top module: `commit_guard`

## Requirements
- R1: While reset is held, commitValid, pipeReset, coreFlush, injectZero, faultCause and faultCount are all zero.
- R2: An instruction sampled in the run state with no error flag set drives commitValid high in the following cycle only. In that cycle commitPc and commitData equal its PC and its result.
- R3: Fault priority from highest to lowest is: timer expiry, register-operand error, memory-operand error, computation error. faultCause is one-hot with bit 0 for timer expiry, bit 1 for register, bit 2 for memory and bit 3 for computation, and it holds the winning cause of the most recent fault.
- R4: During recovery, injectData carries the repair value that belongs to the winning cause. A timer fault instead gives injectData zero with injectZero high. For every other cause injectZero is low.
- R5: A fault sampled in the run state drives pipeReset and coreFlush high for exactly the following cycle. For a checker fault, pipeRestartPc equals the instruction's PC and coreRestartPc equals its next PC.
- R6: Instructions presented during the recovery cycle and the single cycle after it are ignored: they cause no commit and no new fault.
- R7: The timer reloads to WDOG_MAX on every commit and every fault. After a reload, if WDOG_MAX run-state cycles pass without a commit, the next sampled cycle raises a timer fault.
- R8: The timer holds its count during the recovery cycle and the cycle after it. With the core idle, successive timer faults are therefore WDOG_MAX+3 cycles apart.
- R9: faultCount increments by one for each fault and saturates at its all-ones value.
- R10: On a timer fault, pipeRestartPc equals the next PC of the last committed instruction, or RESET_PC if nothing has committed. coreRestartPc equals that value plus PC_STEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A checked instruction is presented |
| instPc | input | PC_W | PC of the presented instruction |
| instNextPc | input | PC_W | PC of its successor |
| instResult | input | DATA_W | Result computed by the core |
| regErr | input | 1 | Register-operand check failed |
| regFix | input | DATA_W | Correct register operand |
| memErr | input | 1 | Memory-operand check failed |
| memFix | input | DATA_W | Correct memory operand |
| compErr | input | 1 | Computation check failed |
| compFix | input | DATA_W | Recomputed result |
| commitValid | output | 1 | Retire strobe |
| commitPc | output | PC_W | PC of the retiring instruction |
| commitData | output | DATA_W | Result being retired |
| pipeReset | output | 1 | Reset checker pipes with the repair value |
| coreFlush | output | 1 | Flush the core |
| pipeRestartPc | output | PC_W | Checker restart PC |
| coreRestartPc | output | PC_W | Core restart PC |
| injectData | output | DATA_W | Repair value injected into the checker pipes |
| injectZero | output | 1 | Instruction injected with zeroed operands |
| faultCause | output | 4 | One-hot cause of the most recent fault |
| faultCount | output | CNT_W | Saturating count of corrected faults |

## Verification
A corrupted priority decision shows in the very next cycle as the wrong faultCause bit and the wrong injectData, so every combination of checker flags is driven and compared against the lowest-indexed set flag. A recovery state that lingers or is skipped shows as a commit during the two ignored cycles, or as a shifted timer period. The timer period is therefore measured edge by edge, both from reset and between back-to-back expiries. A wrong tracked PC only surfaces at the next timer fault, so a commit is followed by a deliberate stall. A timer expiry that coincides with a checker fault exposes the ordering between the two.

// File: rtl/commit_guard_pkg.sv
package commit_guard_pkg;
  localparam int NUM_FAULTS = 4;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_RECOVER = 2'd1,
    ST_RESUME  = 2'd2
  } cgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  doCommit;
    logic                  doFault;
    logic [NUM_FAULTS-1:0] causeSel;
    logic                  holdFlush;
  } cgStrobe_t;
endpackage

// File: rtl/commit_guard_ctrl.sv
module commit_guard_ctrl
  import commit_guard_pkg::*;
#(
  parameter int WDOG_MAX = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      instValid,
  input  logic      regErr,
  input  logic      memErr,
  input  logic      compErr,
  output cgStrobe_t strb
);
  localparam int WD_W = $clog2(WDOG_MAX + 1);
  localparam logic [WD_W-1:0] WD_RELOAD = WD_W'(WDOG_MAX);

  cgState_e state, nextState;
  logic [WD_W-1:0] wdCnt;
  logic expired;
  logic [NUM_FAULTS-1:0] raw, sel;

  always_comb begin
    expired = (wdCnt == '0);
    raw = {compErr & instValid, memErr & instValid, regErr & instValid, expired};
    sel = '0;
    // lowest index has highest priority, so it is visited last
    for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
      if (raw[i]) sel = NUM_FAULTS'(1) << i;
    end
    strb = '0;
    nextState = state;
    case (state)
      ST_RUN: begin
        if (|raw) begin
          strb.doFault  = 1'b1;
          strb.causeSel = sel;
          nextState     = ST_RECOVER;
        end else if (instValid) begin
          strb.doCommit = 1'b1;
        end
      end
      ST_RECOVER: begin
        strb.holdFlush = 1'b1;
        nextState      = ST_RESUME;
      end
      ST_RESUME: nextState = ST_RUN;
      default:   nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      wdCnt <= WD_RELOAD;
    end else begin
      state <= nextState;
      if (strb.doCommit || strb.doFault) wdCnt <= WD_RELOAD;
      else if (state == ST_RUN && wdCnt != '0) wdCnt <= wdCnt - 1'b1;
    end
  end

  // R7
  wdog_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdCnt == '0 && state == ST_RUN) |=> (state == ST_RECOVER));

  // R8
  wdog_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN) |=> $stable(wdCnt));

  // R5
  recover_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER) |=> (state == ST_RESUME));
endmodule

// File: rtl/commit_guard_dp.sv
module commit_guard_dp
  import commit_guard_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int PC_STEP  = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cgStrobe_t             strb,
  input  logic [PC_W-1:0]       instPc,
  input  logic [PC_W-1:0]       instNextPc,
  input  logic [DATA_W-1:0]     instResult,
  input  logic [DATA_W-1:0]     regFix,
  input  logic [DATA_W-1:0]     memFix,
  input  logic [DATA_W-1:0]     compFix,
  output logic                  commitValid,
  output logic [PC_W-1:0]       commitPc,
  output logic [DATA_W-1:0]     commitData,
  output logic                  pipeReset,
  output logic                  coreFlush,
  output logic [PC_W-1:0]       pipeRestartPc,
  output logic [PC_W-1:0]       coreRestartPc,
  output logic [DATA_W-1:0]     injectData,
  output logic                  injectZero,
  output logic [NUM_FAULTS-1:0] faultCause,
  output logic [CNT_W-1:0]      faultCount
);
  logic [PC_W-1:0]   expPc;
  logic [DATA_W-1:0] fixVals [NUM_FAULTS];
  logic [DATA_W-1:0] fixSel;
  logic              wdogWin;

  assign fixVals[0] = '0;
  assign fixVals[1] = regFix;
  assign fixVals[2] = memFix;
  assign fixVals[3] = compFix;
  assign wdogWin    = strb.causeSel[0];

  always_comb begin
    fixSel = '0;
    for (int i = 0; i < NUM_FAULTS; i++) begin
      if (strb.causeSel[i]) fixSel = fixSel | fixVals[i];
    end
  end

  assign pipeReset = strb.holdFlush;
  assign coreFlush = strb.holdFlush;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expPc         <= RESET_PC;
      commitValid   <= 1'b0;
      commitPc      <= '0;
      commitData    <= '0;
      pipeRestartPc <= '0;
      coreRestartPc <= '0;
      injectData    <= '0;
      injectZero    <= 1'b0;
      faultCause    <= '0;
      faultCount    <= '0;
    end else begin
      commitValid <= strb.doCommit;
      if (strb.doCommit) begin
        commitPc   <= instPc;
        commitData <= instResult;
        expPc      <= instNextPc;
      end
      if (strb.doFault) begin
        faultCause <= strb.causeSel;
        injectData <= fixSel;
        injectZero <= wdogWin;
        if (wdogWin) begin
          pipeRestartPc <= expPc;
          coreRestartPc <= expPc + PC_W'(PC_STEP);
        end else begin
          pipeRestartPc <= instPc;
          coreRestartPc <= instNextPc;
        end
        if (faultCount != '1) faultCount <= faultCount + 1'b1;
      end
    end
  end

  // R3
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(faultCause));

  // R6
  no_commit_in_recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    pipeReset |=> !commitValid);

  // R2
  commit_flush_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(commitValid && pipeReset));

  // R9
  count_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultCount >= $past(faultCount));

  // R4
  zero_inject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeReset && injectZero) |-> (injectData == '0 && faultCause[0]));
endmodule

// File: rtl/commit_guard.sv
module commit_guard
  import commit_guard_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int WDOG_MAX = 64,
  parameter int PC_STEP  = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [PC_W-1:0]   instPc,
  input  logic [PC_W-1:0]   instNextPc,
  input  logic [DATA_W-1:0] instResult,
  input  logic              regErr,
  input  logic [DATA_W-1:0] regFix,
  input  logic              memErr,
  input  logic [DATA_W-1:0] memFix,
  input  logic              compErr,
  input  logic [DATA_W-1:0] compFix,
  output logic              commitValid,
  output logic [PC_W-1:0]   commitPc,
  output logic [DATA_W-1:0] commitData,
  output logic              pipeReset,
  output logic              coreFlush,
  output logic [PC_W-1:0]   pipeRestartPc,
  output logic [PC_W-1:0]   coreRestartPc,
  output logic [DATA_W-1:0] injectData,
  output logic              injectZero,
  output logic [3:0]        faultCause,
  output logic [CNT_W-1:0]  faultCount
);
  cgStrobe_t strb;

  commit_guard_ctrl #(.WDOG_MAX(WDOG_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid),
    .regErr(regErr), .memErr(memErr), .compErr(compErr), .strb(strb)
  );

  commit_guard_dp #(
    .PC_W(PC_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .instPc(instPc), .instNextPc(instNextPc), .instResult(instResult),
    .regFix(regFix), .memFix(memFix), .compFix(compFix),
    .commitValid(commitValid), .commitPc(commitPc), .commitData(commitData),
    .pipeReset(pipeReset), .coreFlush(coreFlush),
    .pipeRestartPc(pipeRestartPc), .coreRestartPc(coreRestartPc),
    .injectData(injectData), .injectZero(injectZero),
    .faultCause(faultCause), .faultCount(faultCount)
  );
endmodule

// File: tb/commit_guard_bench.sv
module commit_guard_bench;
  localparam int PC_W = 16, DATA_W = 16, CNT_W = 4, WDOG_MAX = 8, PC_STEP = 4;
  localparam logic [15:0] RESET_PC = 16'h0100;

  logic clk = 1'b0, rstN = 1'b0;
  logic instValid = 1'b0, regErr = 1'b0, memErr = 1'b0, compErr = 1'b0;
  logic [15:0] instPc = '0, instNextPc = '0, instResult = '0;
  logic [15:0] regFix = '0, memFix = '0, compFix = '0;
  logic commitValid, pipeReset, coreFlush, injectZero;
  logic [15:0] commitPc, commitData, pipeRestartPc, coreRestartPc, injectData;
  logic [3:0] faultCause;
  logic [CNT_W-1:0] faultCount;

  int total = 0, bad = 0;
  int expCnt = 0;

  always #10 clk = ~clk;

  commit_guard #(
    .PC_W(PC_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WDOG_MAX(WDOG_MAX),
    .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
  ) u_commit_guard (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instPc(instPc),
    .instNextPc(instNextPc), .instResult(instResult),
    .regErr(regErr), .regFix(regFix), .memErr(memErr), .memFix(memFix),
    .compErr(compErr), .compFix(compFix),
    .commitValid(commitValid), .commitPc(commitPc), .commitData(commitData),
    .pipeReset(pipeReset), .coreFlush(coreFlush),
    .pipeRestartPc(pipeRestartPc), .coreRestartPc(coreRestartPc),
    .injectData(injectData), .injectZero(injectZero),
    .faultCause(faultCause), .faultCount(faultCount)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one instruction, sample just after the next edge
  task automatic present(input logic [15:0] pc, input logic [15:0] res, input logic [2:0] err,
                         input logic [15:0] rf, input logic [15:0] mf, input logic [15:0] cf);
    @(negedge clk);
    instValid = 1'b1; instPc = pc; instNextPc = pc + 16'd4; instResult = res;
    regErr = err[0]; memErr = err[1]; compErr = err[2];
    regFix = rf; memFix = mf; compFix = cf;
    @(posedge clk); #1;
    instValid = 1'b0; regErr = 1'b0; memErr = 1'b0; compErr = 1'b0;
  endtask

  task automatic bumpCnt();
    if (expCnt < 15) expCnt++;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: run hung actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk(commitValid == 0 && pipeReset == 0 && coreFlush == 0 && injectZero == 0, "R1 strobes", {commitValid, pipeReset, coreFlush, injectZero}, 0);
    chk(faultCause == 0, "R1 cause", faultCause, 0);
    chk(faultCount == 0, "R1 count", faultCount, 0);
    @(negedge clk); rstN = 1'b1;

    // R7 first expiry after reset on edge WDOG_MAX+1, plus R10 with RESET_PC
    for (int k = 1; k <= WDOG_MAX + 1; k++) begin
      @(posedge clk); #1;
      chk(pipeReset == (k == WDOG_MAX + 1), "R7 expiry timing", pipeReset, k == WDOG_MAX + 1);
    end
    bumpCnt();
    chk(faultCause == 4'b0001, "R3 wdog cause", faultCause, 4'b0001);
    chk(injectZero == 1 && injectData == 0, "R4 zero inject", injectData, 0);
    chk(pipeRestartPc == RESET_PC, "R10 restart pc", pipeRestartPc, RESET_PC);
    chk(coreRestartPc == RESET_PC + PC_STEP, "R10 core pc", coreRestartPc, RESET_PC + PC_STEP);
    chk(coreFlush == 1, "R5 flush", coreFlush, 1);

    // R8 back-to-back expiry period
    for (int k = 1; k <= WDOG_MAX + 3; k++) begin
      @(posedge clk); #1;
      chk(pipeReset == (k == WDOG_MAX + 3), "R8 period", pipeReset, k == WDOG_MAX + 3);
      if (k == 1) chk(pipeReset == 0, "R5 one cycle", pipeReset, 0);
    end
    bumpCnt();
    chk(faultCount == 4'(expCnt), "R9 count", faultCount, expCnt);

    // consume the two recovery-follow cycles with ignored instructions
    for (int j = 0; j < 2; j++) begin
      present(16'h0F00, 16'hDEAD, 3'b000, 0, 0, 0);
      chk(commitValid == 0 && pipeReset == 0, "R6 ignored", {commitValid, pipeReset}, 0);
    end

    // sweep every flag combination, three rounds
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 8; c++) begin
        logic [15:0] pc, res, rf, mf, cf, expFix;
        logic [3:0] expCause;
        pc  = 16'h1000 + 16'(r * 256) + 16'(c * 16);
        res = 16'hA000 ^ 16'(r << 4) ^ 16'(c);
        rf  = 16'h1100 + 16'(c); mf = 16'h2200 + 16'(c); cf = 16'h3300 + 16'(c);
        present(pc, res, 3'(c), rf, mf, cf);
        if (c == 0) begin
          chk(commitValid == 1 && pipeReset == 0, "R2 commit", {commitValid, pipeReset}, 2'b10);
          chk(commitPc == pc && commitData == res, "R2 data", {commitPc, commitData}, {pc, res});
          @(posedge clk); #1;
          chk(commitValid == 0, "R2 single pulse", commitValid, 0);
        end else begin
          if (c[0]) begin expCause = 4'b0010; expFix = rf; end
          else if (c[1]) begin expCause = 4'b0100; expFix = mf; end
          else begin expCause = 4'b1000; expFix = cf; end
          bumpCnt();
          chk(pipeReset == 1 && coreFlush == 1 && commitValid == 0, "R5 recover", {pipeReset, coreFlush, commitValid}, 3'b110);
          chk(faultCause == expCause, "R3 priority", faultCause, expCause);
          chk(injectData == expFix && injectZero == 0, "R4 fix value", injectData, expFix);
          chk(pipeRestartPc == pc && coreRestartPc == pc + 16'd4, "R5 pcs", {pipeRestartPc, coreRestartPc}, {pc, pc + 16'd4});
          chk(faultCount == 4'(expCnt), "R9 count", faultCount, expCnt);
          for (int j = 0; j < 2; j++) begin
            present(pc + 16'h8, res, 3'b111, 0, 0, 0);
            chk(commitValid == 0 && pipeReset == 0, "R6 ignored", {commitValid, pipeReset}, 0);
            chk(faultCause == expCause && faultCount == 4'(expCnt), "R6 no new fault", faultCause, expCause);
          end
        end
      end
    end
    chk(faultCount == 4'd15, "R9 saturate", faultCount, 15);

    // R10 + R3: commit, stall, expiry coincides with a register error
    present(16'h01FC, 16'h5555, 3'b000, 0, 0, 0);
    chk(commitValid == 1 && commitPc == 16'h01FC, "R2 commit", commitPc, 16'h01FC);
    for (int k = 1; k <= WDOG_MAX; k++) begin
      @(posedge clk); #1;
      chk(pipeReset == 0, "R7 no early expiry", pipeReset, 0);
    end
    present(16'h0300, 16'h7777, 3'b001, 16'h9999, 0, 0);
    chk(pipeReset == 1 && faultCause == 4'b0001, "R3 wdog beats reg", faultCause, 4'b0001);
    chk(pipeRestartPc == 16'h0200, "R10 tracked pc", pipeRestartPc, 16'h0200);
    chk(coreRestartPc == 16'h0204, "R10 core pc", coreRestartPc, 16'h0204);
    chk(injectZero == 1 && injectData == 0, "R4 zero inject", injectData, 0);
    chk(faultCount == 4'd15, "R9 held at max", faultCount, 15);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule